// File: doc/BRIEF.md
# Debug Clock Gating Controller

This block decides, cycle by cycle, whether a small processor core receives its clock. It drives a registered enable meant for a standard clock-gate cell. Debug logic uses it to freeze the core, to resume free running, and to advance the core by exactly one clock at a time. This lets a halted core be inspected and compared register by register against a simulator.

A free-running counter records every cycle in which the enable was high. When compare is armed, the core halts exactly as the counter reaches a programmed value. A halt can therefore be placed on the same cycle in silicon and in simulation.

Stop and step requests can come from synchronous on-chip logic or from asynchronous external pins. External requests are synchronized and edge detected, so a held level acts only once. Their alignment to the cycle count is not defined.

Top module: `dcg_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `core_en` is 0, `halted` is 1 and `cycle_count` is 0 until a run or step request arrives.
- R2: A `run_req` pulse while halted, with no stop event in the same cycle, sets `core_en` to 1 and `halted` to 0 from the next cycle on. While `halted` is 0, `core_en` is 1.
- R3: `cycle_count` increases by exactly one after every cycle in which `core_en` is 1 and holds its value after every cycle in which `core_en` is 0.
- R4: With `cmp_en` at 1, an enabled cycle that takes `cycle_count` to `cmp_value` is the last enabled cycle. Afterwards `cycle_count` equals `cmp_value`, `core_en` is 0 and `halted` is 1.
- R5: With `cmp_en` at 0, a match of `cycle_count` and `cmp_value` does not stop the core.
- R6: `int_stop` high in a cycle gives `core_en` 0 and `halted` 1 in the next cycle.
- R7: `ext_stop_async` passes through SYNC_STAGES flops and a rising-edge detector before it stops the core, within SYNC_STAGES+2 cycles. A level held high acts only once, so a later `run_req` still resumes the core.
- R8: A rising edge on `int_step` (next cycle), or a synchronized rising edge on `ext_step_async`, while halted gives exactly one cycle of `core_en`. The count advances by one and the core returns to halted. `halted` stays 1 during the step cycle.
- R9: A step request while the core is running is ignored: `core_en` stays 1 and `halted` stays 0.
- R10: A stop event takes priority over a run or step request in the same cycle. The core then stays halted and the count does not move.
- R11: `halted` is 0 exactly while the core is free running.
- R12: `cycle_count` wraps to 0 after 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Synchronous resume request |
| int_stop | input | 1 | Synchronous stop from on-chip logic |
| int_step | input | 1 | Synchronous step request, rising edge acts |
| ext_stop_async | input | 1 | Asynchronous stop pin |
| ext_step_async | input | 1 | Asynchronous step pin |
| cmp_en | input | 1 | Arms the cycle compare stop |
| cmp_value | input | CNT_W | Cycle number at which to halt |
| core_en | output | 1 | Registered enable for the core clock gate |
| halted | output | 1 | 1 unless free running |
| cycle_count | output | CNT_W | Count of enabled core cycles |

## Verification
The bench targets the compare stop landing one cycle late or early: the count would read `cmp_value`±1 after the halt. It checks that a held external level fires once; a design without edge detection would refuse the later resume. Other targets are a step request during running, which a faulty design turns into a stop, and simultaneous stop and run or step, where losing the priority lets the count move. A random phase compares enable, status and count every cycle against a bench model. A narrow counter exposes the wrap.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
   typedef enum logic [1:0] {
      GM_STOPPED  = 2'd0,
      GM_RUNNING  = 2'd1,
      GM_STEPPING = 2'd2
   } gate_mode_e;

   function automatic logic mode_enables(gate_mode_e m);
      return (m != GM_STOPPED);
   endfunction
endpackage

// File: rtl/dcg_req_sync.sv
module dcg_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic pulse_out
);
   logic lvl;
   logic prev_q;

   if (STAGES == 0) begin : g_direct
      assign lvl = req_in;
   end else if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b0;
         else        s_q <= req_in;
      end
      assign lvl = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], req_in};
      end
      assign lvl = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign pulse_out = lvl & ~prev_q;
endmodule

// File: rtl/dcg_cycle_ctr.sv
module dcg_cycle_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             cmp_en,
   input  logic [CNT_W-1:0] cmp_value,
   output logic [CNT_W-1:0] count,
   output logic             cmp_hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (adv) cnt_q <= cnt_inc;
   end

   assign cmp_hit = cmp_en & adv & (cnt_inc == cmp_value);
   assign count   = cnt_q;
endmodule

// File: rtl/dcg_gate_fsm.sv
module dcg_gate_fsm
   import dcg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_req,
   input  logic       stop_evt,
   input  logic       step_evt,
   output gate_mode_e mode,
   output logic       core_en
);
   gate_mode_e mode_q, mode_d;
   logic       en_q;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         GM_STOPPED: begin
            if (stop_evt)      mode_d = GM_STOPPED;
            else if (run_req)  mode_d = GM_RUNNING;
            else if (step_evt) mode_d = GM_STEPPING;
         end
         GM_RUNNING: begin
            if (stop_evt) mode_d = GM_STOPPED;
         end
         GM_STEPPING: begin
            if (stop_evt)     mode_d = GM_STOPPED;
            else if (run_req) mode_d = GM_RUNNING;
            else              mode_d = GM_STOPPED;
         end
         default: mode_d = GM_STOPPED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= GM_STOPPED;
         en_q   <= 1'b0;
      end else begin
         mode_q <= mode_d;
         en_q   <= mode_enables(mode_d);
      end
   end

   assign mode    = mode_q;
   assign core_en = en_q;
endmodule

// File: rtl/dcg_ctrl.sv
module dcg_ctrl
   import dcg_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic             int_stop,
   input  logic             int_step,
   input  logic             ext_stop_async,
   input  logic             ext_step_async,
   input  logic             cmp_en,
   input  logic [CNT_W-1:0] cmp_value,
   output logic             core_en,
   output logic             halted,
   output logic [CNT_W-1:0] cycle_count
);
   if (CNT_W < 2) begin : g_bad_width
      $error("dcg_ctrl: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dcg_ctrl: SYNC_STAGES must be at least 2");
   end

   logic       ext_stop_p, ext_step_p, int_step_p;
   logic       cmp_hit, stop_evt, step_evt;
   gate_mode_e mode;

   dcg_req_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
      .clk(clk_ref), .rst_n(rst_n), .req_in(ext_stop_async), .pulse_out(ext_stop_p));

   dcg_req_sync #(.STAGES(SYNC_STAGES)) u_sync_step (
      .clk(clk_ref), .rst_n(rst_n), .req_in(ext_step_async), .pulse_out(ext_step_p));

   dcg_req_sync #(.STAGES(0)) u_edge_istep (
      .clk(clk_ref), .rst_n(rst_n), .req_in(int_step), .pulse_out(int_step_p));

   dcg_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk_ref), .rst_n(rst_n), .adv(core_en), .cmp_en(cmp_en),
      .cmp_value(cmp_value), .count(cycle_count), .cmp_hit(cmp_hit));

   assign stop_evt = int_stop | ext_stop_p | cmp_hit;
   assign step_evt = int_step_p | ext_step_p;

   dcg_gate_fsm u_fsm (
      .clk(clk_ref), .rst_n(rst_n), .run_req(run_req), .stop_evt(stop_evt),
      .step_evt(step_evt), .mode(mode), .core_en(core_en));

   assign halted = (mode != GM_RUNNING);
endmodule

// File: rtl/dcg_ctrl_chk.sv
module dcg_ctrl_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk_ref,
   input logic             rst_n,
   input logic             run_req,
   input logic             int_stop,
   input logic             cmp_en,
   input logic [CNT_W-1:0] cmp_value,
   input logic             core_en,
   input logic             halted,
   input logic [CNT_W-1:0] cycle_count
);
   p_hold_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !core_en |=> $stable(cycle_count));

   p_inc_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      core_en |=> cycle_count == CNT_W'($past(cycle_count) + 1'b1));

   p_cmp_stop_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (cmp_en && core_en && (CNT_W'(cycle_count + 1'b1) == cmp_value)) |=> (halted && !core_en));

   p_int_stop_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      int_stop |=> (halted && !core_en));

   p_step_one_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (halted && core_en) |=> (!core_en || !halted));

   p_run_en_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !halted |-> core_en);
endmodule

bind dcg_ctrl dcg_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_ref(clk_ref), .rst_n(rst_n), .run_req(run_req), .int_stop(int_stop),
   .cmp_en(cmp_en), .cmp_value(cmp_value), .core_en(core_en),
   .halted(halted), .cycle_count(cycle_count));

// File: tb/tb_dcg_ctrl.sv
module tb_dcg_ctrl;
   localparam int CW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic run_req = 0, int_stop = 0, int_step = 0, ext_stop = 0, ext_step = 0, cmp_en = 0;
   logic [CW-1:0] cmp_value = '0;
   logic core_en, halted;
   logic [CW-1:0] cycle_count;

   int n_chk = 0, n_bad = 0, c = 0;
   bit finished = 0;
   int m_mode = 0, m_en = 0, m_cnt = 0, m_pstep = 0;

   always #10 clk = ~clk;

   dcg_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
      .clk_ref(clk), .rst_n(rst_n), .run_req(run_req), .int_stop(int_stop),
      .int_step(int_step), .ext_stop_async(ext_stop), .ext_step_async(ext_step),
      .cmp_en(cmp_en), .cmp_value(cmp_value), .core_en(core_en),
      .halted(halted), .cycle_count(cycle_count));

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_run();
      run_req = 1; tick(); run_req = 0;
   endtask

   function automatic int wrap(int v);
      return v % (1 << CW);
   endfunction

   // bench reference: next mode from current mode and this cycle's inputs
   function automatic int next_mode(int mode, bit stop, bit run, bit stp);
      case (mode)
         0: return stop ? 0 : (run ? 1 : (stp ? 2 : 0));
         1: return stop ? 0 : 1;
         default: return stop ? 0 : (run ? 1 : 0);
      endcase
   endfunction

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      tick(3);
      chk("R1 core_en in reset", core_en, 0);
      chk("R1 halted in reset", halted, 1);
      rst_n = 1; tick(2);
      chk("R1 count after reset", cycle_count, 0);
      chk("R1 core_en after reset", core_en, 0);

      pulse_run();
      chk("R2 core_en after run", core_en, 1);
      chk("R2 halted after run", halted, 0);
      chk("R3 count at start", cycle_count, 0);
      tick(10);
      chk("R3 count after 10", cycle_count, 10);

      int_step = 1; tick(); int_step = 0;
      chk("R9 core_en after step in run", core_en, 1);
      chk("R9 halted after step in run", halted, 0);
      tick(2);

      int_stop = 1; tick(); int_stop = 0;
      chk("R6 core_en after int_stop", core_en, 0);
      chk("R6 halted after int_stop", halted, 1);
      c = cycle_count; tick(5);
      chk("R3 hold while halted", cycle_count, c);

      int_step = 1; tick();
      chk("R8 step pulse core_en", core_en, 1);
      chk("R8 halted during step", halted, 1);
      int_step = 0; tick();
      chk("R8 core_en after step", core_en, 0);
      tick(3);
      chk("R8 count after int step", cycle_count, c + 1);

      ext_step = 1; tick(12);
      chk("R8 count after held ext step", cycle_count, c + 2);
      chk("R7 core_en after held ext step", core_en, 0);
      ext_step = 0; tick(4);

      pulse_run(); tick(3);
      ext_stop = 1; tick(5);
      chk("R7 halted after ext stop", halted, 1);
      chk("R7 core_en after ext stop", core_en, 0);
      c = cycle_count; tick(5);
      chk("R3 hold after ext stop", cycle_count, c);
      pulse_run();
      chk("R7 held stop acts once", core_en, 1);
      int_stop = 1; tick(); int_stop = 0;
      ext_stop = 0; tick(4);

      c = cycle_count;
      int_stop = 1; run_req = 1; tick(); int_stop = 0; run_req = 0;
      chk("R10 stop beats run", halted, 1);
      int_stop = 1; int_step = 1; tick(); int_stop = 0; int_step = 0;
      chk("R10 stop beats step", core_en, 0);
      tick(2);
      chk("R10 count unmoved", cycle_count, c);

      cmp_value = CW'(c + 5); cmp_en = 1;
      pulse_run(); tick(10);
      chk("R4 count at compare halt", cycle_count, wrap(c + 5));
      chk("R4 halted at compare", halted, 1);
      chk("R4 core_en at compare", core_en, 0);
      pulse_run(); tick(3);
      chk("R2 resume past compare", halted, 0);
      int_stop = 1; tick(); int_stop = 0;

      cmp_en = 0; c = cycle_count; cmp_value = CW'(c + 3);
      pulse_run(); tick(7);
      chk("R5 no stop when disarmed", core_en, 1);
      chk("R5 count disarmed", cycle_count, wrap(c + 7));
      c = cycle_count; tick(300);
      chk("R12 wrap", cycle_count, wrap(c + 300));
      int_stop = 1; tick(); int_stop = 0; tick();

      // random phase against bench model
      m_mode = 0; m_en = 0; m_cnt = cycle_count; m_pstep = 0;
      for (int i = 0; i < 3000; i++) begin
         bit hit, stp;
         if (core_en !== m_en[0]) chk("R3 random core_en", core_en, m_en);
         else n_chk++;
         if (halted !== (m_mode != 1)) chk("R11 random halted", halted, m_mode != 1);
         else n_chk++;
         if (cycle_count !== CW'(m_cnt)) chk("R3 random count", cycle_count, m_cnt);
         else n_chk++;
         run_req  = ($urandom % 8) == 0;
         int_stop = ($urandom % 16) == 0;
         int_step = ($urandom % 4) == 0;
         cmp_en   = $urandom % 2;
         if ($urandom % 8 == 0) cmp_value = CW'(m_cnt + ($urandom % 6));
         hit = cmp_en && (m_en != 0) && (CW'(m_cnt + 1) == cmp_value);
         stp = int_step && (m_pstep == 0);
         m_mode  = next_mode(m_mode, int_stop || hit, run_req, stp);
         m_cnt   = wrap(m_cnt + m_en);
         m_en    = (m_mode != 0);
         m_pstep = int_step;
         tick();
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule